// File: doc/BRIEF.md
# Cipher DMA Register Front-End

This block is the software-visible register file of a block-cipher DMA engine. It sits between a simple 32-bit register port and the engine's sequencer. Software programs a source and a destination address, loads a 128-bit key and a 128-bit initialisation vector through two write-only word ports, and launches a command through the control word. The control word carries the cipher direction, a pass-through option that copies data unchanged, a chaining flag and the block count.

The sequencer reads the command fields and the assembled key and IV. It reports busy, error and completion, and writes the advancing source and destination addresses back as blocks finish. One control bit has split meaning. Writing 1 to it launches a command, writing 0 to it resets the engine, and reading it returns busy. An interrupt line is raised on completion when enabled and is held until software next writes the control word.

The cipher datapath, the memory transactions and the bus fabric are outside this block.

Top module: `cdma_regs`

## Requirements
- R1: After reset all registers, the command outputs, the key, the IV, both addresses and irq_o are zero, and both word pointers are at word 0.
- R2: A write at offset 0x00 stores IRQ enable (bit 30), cipher enable (bit 28), decrypt (bit 27), chain (bit 12) and block count minus one (bits 11:0). These drive the command outputs and read back at the same positions. Bits 26:13 read as zero.
- R3: A control write with bit 31 = 1 drives cmd_start_o high for exactly the one cycle after the write, and cmd_reset_o stays low.
- R4: A control write with bit 31 = 0 drives cmd_reset_o high for the one cycle after the write and returns both word pointers to word 0.
- R5: Bit 31 of the control read is 1 while seq_busy_i is high or a start pulse is pending, and 0 otherwise.
- R6: Bit 29 (error) is loaded from a control write and is set by a seq_err_i pulse. It stays set until a control write clears it. When both happen in one cycle, the pulse wins.
- R7: Four writes at offset 0x0C fill key_o from the most significant word down (first write goes to [127:96]). The fifth write wraps to [127:96].
- R8: Four writes at offset 0x10 fill iv_o in the same order and wrap in the same way.
- R9: Reads at offsets 0x0C and 0x10 return zero.
- R10: Writes at 0x04 and 0x08 set src_addr_o and dst_addr_o with bits 3:0 forced to zero, and these registers read back at the same offsets.
- R11: seq_wb_i loads seq_src_i and seq_dst_i into the two address registers, with bits 3:0 forced to zero. A software write to one of them in the same cycle takes priority for that register.
- R12: seq_done_i while IRQ enable is set raises irq_o on the next cycle. irq_o holds until a control write. A completion in the same cycle as a control write leaves irq_o set.
- R13: Offsets above 0x10, or with address bits 1:0 non-zero, read zero and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Byte offset of access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from offset |
| seq_busy_i | input | 1 | Sequencer running |
| seq_err_i | input | 1 | Sequencer error pulse |
| seq_done_i | input | 1 | Command complete pulse |
| seq_wb_i | input | 1 | Address write-back strobe |
| seq_src_i | input | 32 | Advanced source address |
| seq_dst_i | input | 32 | Advanced destination address |
| cmd_start_o | output | 1 | One-cycle launch pulse |
| cmd_reset_o | output | 1 | One-cycle engine reset pulse |
| cmd_decrypt_o | output | 1 | 1 decrypt, 0 encrypt |
| cmd_cipher_en_o | output | 1 | 0 copies data unchanged |
| cmd_chain_o | output | 1 | Continue chaining from the previous command |
| cmd_blocks_o | output | 12 | Block count minus one |
| key_o | output | 128 | Assembled key |
| iv_o | output | 128 | Assembled IV |
| src_addr_o | output | 32 | Source address |
| dst_addr_o | output | 32 | Destination address |
| irq_o | output | 1 | Completion interrupt |

## Verification
A word pointer that has drifted puts the next key or IV word into the wrong slice of key_o or iv_o. This shows at the ports on the edge right after that write and stays visible until the slot is rewritten. A wrong decode or control field shows on the next combinational read or on the command outputs in the same cycle. A pulse or sticky-flag error (start, reset, error, interrupt) shows one cycle after its cause, so the bench samples these at the falling edge that follows each stimulus.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BLK_W  = 12;

  // word index of each register
  localparam int unsigned OFF_CTRL = 0;
  localparam int unsigned OFF_SRC  = 1;
  localparam int unsigned OFF_DST  = 2;
  localparam int unsigned OFF_KEY  = 3;
  localparam int unsigned OFF_IV   = 4;

  localparam int unsigned EXEC_BIT  = 31;
  localparam int unsigned IRQEN_BIT = 30;
  localparam int unsigned ERR_BIT   = 29;
  localparam int unsigned CIPH_BIT  = 28;
  localparam int unsigned DEC_BIT   = 27;
  localparam int unsigned CHAIN_BIT = 12;

  typedef struct packed {
    logic             irq_en;
    logic             cipher_en;
    logic             decrypt;
    logic             chain;
    logic [BLK_W-1:0] blocks;
  } cdma_cmd_t;
endpackage

// File: rtl/cdma_word_fifo.sv
module cdma_word_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic                    clr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W*WORDS-1:0] data_o
);
  localparam int unsigned PTR_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(WORDS - 1);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (clr_i)    ptr_q <= '0;
    else if (wr_i)     ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  // word 0 is the most significant
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         word_q <= '0;
      else if (wr_i && !clr_i && ptr_q == PTR_W'(i))       word_q <= wdata_i;
    end
    assign data_o[DATA_W*(WORDS-i)-1 -: DATA_W] = word_q;
  end

  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i && ptr_q == LAST) |=> (ptr_q == '0)); // R7
  AST_PTR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ptr_q == '0)); // R4
endmodule

// File: rtl/cdma_addr_reg.sv
module cdma_addr_reg #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ALIGN_BITS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_wr_i,
  input  logic [DATA_W-1:0] sw_data_i,
  input  logic              hw_wr_i,
  input  logic [DATA_W-1:0] hw_data_i,
  output logic [DATA_W-1:0] addr_o
);
  localparam logic [DATA_W-1:0] KEEP = ~((DATA_W'(1) << ALIGN_BITS) - DATA_W'(1));

  logic [DATA_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (sw_wr_i)  addr_q <= sw_data_i & KEEP;
    else if (hw_wr_i)  addr_q <= hw_data_i & KEEP;
  end

  assign addr_o = addr_q;

  AST_SW_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_wr_i |=> (addr_o == ($past(sw_data_i) & KEEP))); // R11
  AST_HW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_wr_i && !sw_wr_i) |=> (addr_o == ($past(hw_data_i) & KEEP))); // R11
endmodule

// File: rtl/cdma_ctrl_reg.sv
module cdma_ctrl_reg
  import cdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              seq_busy_i,
  input  logic              seq_err_i,
  input  logic              seq_done_i,
  output cdma_cmd_t         cmd_o,
  output logic              start_o,
  output logic              reset_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] rdata_o
);
  cdma_cmd_t cmd_q;
  logic      err_q, start_q, rst_q, irq_q;
  logic      unused_bits;

  assign unused_bits = ^wdata_i[DEC_BIT-1:CHAIN_BIT+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
      rst_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      start_q <= wr_i &  wdata_i[EXEC_BIT];
      rst_q   <= wr_i & ~wdata_i[EXEC_BIT];
      if (wr_i) begin
        cmd_q.irq_en    <= wdata_i[IRQEN_BIT];
        cmd_q.cipher_en <= wdata_i[CIPH_BIT];
        cmd_q.decrypt   <= wdata_i[DEC_BIT];
        cmd_q.chain     <= wdata_i[CHAIN_BIT];
        cmd_q.blocks    <= wdata_i[BLK_W-1:0];
      end
      if (seq_err_i)  err_q <= 1'b1;
      else if (wr_i)  err_q <= wdata_i[ERR_BIT];
      // completion beats the clearing write
      if (seq_done_i && cmd_q.irq_en) irq_q <= 1'b1;
      else if (wr_i)                  irq_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o              = '0;
    rdata_o[EXEC_BIT]    = seq_busy_i | start_q;
    rdata_o[IRQEN_BIT]   = cmd_q.irq_en;
    rdata_o[ERR_BIT]     = err_q;
    rdata_o[CIPH_BIT]    = cmd_q.cipher_en;
    rdata_o[DEC_BIT]     = cmd_q.decrypt;
    rdata_o[CHAIN_BIT]   = cmd_q.chain;
    rdata_o[BLK_W-1:0]   = cmd_q.blocks;
  end

  assign cmd_o   = cmd_q;
  assign start_o = start_q;
  assign reset_o = rst_q;
  assign irq_o   = irq_q;

  AST_START_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(wr_i && wdata_i[EXEC_BIT])); // R3
  AST_START_NO_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && reset_o)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_i |=> rdata_o[ERR_BIT]); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_i) |=> irq_o); // R12
  AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_done_i && cmd_o.irq_en) |=> irq_o); // R12
endmodule

// File: rtl/cdma_regs.sv
module cdma_regs
  import cdma_pkg::*;
#(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned FIFO_WORDS = 4,
  parameter int unsigned ALIGN_BITS = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         reg_wr_i,
  input  logic [ADDR_W-1:0]            reg_addr_i,
  input  logic [DATA_W-1:0]            reg_wdata_i,
  output logic [DATA_W-1:0]            reg_rdata_o,
  input  logic                         seq_busy_i,
  input  logic                         seq_err_i,
  input  logic                         seq_done_i,
  input  logic                         seq_wb_i,
  input  logic [DATA_W-1:0]            seq_src_i,
  input  logic [DATA_W-1:0]            seq_dst_i,
  output logic                         cmd_start_o,
  output logic                         cmd_reset_o,
  output logic                         cmd_decrypt_o,
  output logic                         cmd_cipher_en_o,
  output logic                         cmd_chain_o,
  output logic [BLK_W-1:0]             cmd_blocks_o,
  output logic [DATA_W*FIFO_WORDS-1:0] key_o,
  output logic [DATA_W*FIFO_WORDS-1:0] iv_o,
  output logic [DATA_W-1:0]            src_addr_o,
  output logic [DATA_W-1:0]            dst_addr_o,
  output logic                         irq_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic              wr_ctrl, wr_src, wr_dst, wr_key, wr_iv;
  logic [DATA_W-1:0] ctrl_rdata;
  cdma_cmd_t         cmd;

  assign idx     = reg_addr_i[ADDR_W-1:2];
  assign aligned = (reg_addr_i[1:0] == 2'b00);
  assign wr_ctrl = reg_wr_i && aligned && idx == IDX_W'(OFF_CTRL);
  assign wr_src  = reg_wr_i && aligned && idx == IDX_W'(OFF_SRC);
  assign wr_dst  = reg_wr_i && aligned && idx == IDX_W'(OFF_DST);
  assign wr_key  = reg_wr_i && aligned && idx == IDX_W'(OFF_KEY);
  assign wr_iv   = reg_wr_i && aligned && idx == IDX_W'(OFF_IV);

  cdma_ctrl_reg u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_ctrl),
    .wdata_i    (reg_wdata_i),
    .seq_busy_i (seq_busy_i),
    .seq_err_i  (seq_err_i),
    .seq_done_i (seq_done_i),
    .cmd_o      (cmd),
    .start_o    (cmd_start_o),
    .reset_o    (cmd_reset_o),
    .irq_o      (irq_o),
    .rdata_o    (ctrl_rdata)
  );

  cdma_word_fifo #(.DATA_W(DATA_W), .WORDS(FIFO_WORDS)) u_key (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_key),
    .clr_i   (cmd_reset_o),
    .wdata_i (reg_wdata_i),
    .data_o  (key_o)
  );

  cdma_word_fifo #(.DATA_W(DATA_W), .WORDS(FIFO_WORDS)) u_iv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_iv),
    .clr_i   (cmd_reset_o),
    .wdata_i (reg_wdata_i),
    .data_o  (iv_o)
  );

  cdma_addr_reg #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_src (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_wr_i   (wr_src),
    .sw_data_i (reg_wdata_i),
    .hw_wr_i   (seq_wb_i),
    .hw_data_i (seq_src_i),
    .addr_o    (src_addr_o)
  );

  cdma_addr_reg #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_dst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_wr_i   (wr_dst),
    .sw_data_i (reg_wdata_i),
    .hw_wr_i   (seq_wb_i),
    .hw_data_i (seq_dst_i),
    .addr_o    (dst_addr_o)
  );

  assign cmd_decrypt_o   = cmd.decrypt;
  assign cmd_cipher_en_o = cmd.cipher_en;
  assign cmd_chain_o     = cmd.chain;
  assign cmd_blocks_o    = cmd.blocks;

  always_comb begin
    reg_rdata_o = '0;
    if (aligned) begin
      if (idx == IDX_W'(OFF_CTRL))     reg_rdata_o = ctrl_rdata;
      else if (idx == IDX_W'(OFF_SRC)) reg_rdata_o = src_addr_o;
      else if (idx == IDX_W'(OFF_DST)) reg_rdata_o = dst_addr_o;
    end
  end

  AST_WO_PORT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aligned && (idx == IDX_W'(OFF_KEY) || idx == IDX_W'(OFF_IV))) |-> (reg_rdata_o == '0)); // R9
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_ctrl, wr_src, wr_dst, wr_key, wr_iv})); // R13
  AST_ALIGNED_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_addr_o[ALIGN_BITS-1:0] == '0) && (dst_addr_o[ALIGN_BITS-1:0] == '0)); // R10
endmodule

// File: tb/cdma_regs_test.sv
`timescale 1ns/1ps
module cdma_regs_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [4:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         seq_busy = 1'b0, seq_err = 1'b0, seq_done = 1'b0, seq_wb = 1'b0;
  logic [31:0]  seq_src = '0, seq_dst = '0;
  logic         cmd_start, cmd_reset, cmd_decrypt, cmd_cipher_en, cmd_chain, irq;
  logic [11:0]  cmd_blocks;
  logic [127:0] key, iv;
  logic [31:0]  src_addr, dst_addr;

  cdma_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .seq_busy_i(seq_busy),
    .seq_err_i(seq_err), .seq_done_i(seq_done), .seq_wb_i(seq_wb),
    .seq_src_i(seq_src), .seq_dst_i(seq_dst), .cmd_start_o(cmd_start),
    .cmd_reset_o(cmd_reset), .cmd_decrypt_o(cmd_decrypt),
    .cmd_cipher_en_o(cmd_cipher_en), .cmd_chain_o(cmd_chain),
    .cmd_blocks_o(cmd_blocks), .key_o(key), .iv_o(iv),
    .src_addr_o(src_addr), .dst_addr_o(dst_addr), .irq_o(irq)
  );

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  // reference model
  logic [31:0]  m_cfg = '0, m_src = '0, m_dst = '0;
  logic         m_err = 1'b0, m_irq = 1'b0, m_start = 1'b0, m_rst = 1'b0;
  logic [127:0] m_key = '0, m_iv = '0;
  int           m_kptr = 0, m_iptr = 0;

  localparam logic [31:0] CFG_MASK = 32'h5800_1FFF;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ctrl();
    logic [31:0] v;
    v = m_cfg;
    v[31] = seq_busy | m_start;
    v[29] = m_err;
    return v;
  endfunction

  task automatic read(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.2;
    d = reg_rdata;
  endtask

  task automatic check_all();
    logic [31:0] d;
    read(5'h00, d); check("R2 ctrl read", d, exp_ctrl());
    read(5'h04, d); check("R10 src read", d, m_src);
    read(5'h08, d); check("R10 dst read", d, m_dst);
    read(5'h0C, d); check("R9 key port read", d, 0);
    read(5'h10, d); check("R9 iv port read", d, 0);
    read(5'h14, d); check("R13 unmapped read", d, 0);
    check("R7 key", key, m_key);
    check("R8 iv", iv, m_iv);
    check("R2 cmd fields", {cmd_decrypt, cmd_cipher_en, cmd_chain, cmd_blocks},
          {m_cfg[27], m_cfg[28], m_cfg[12], m_cfg[11:0]});
    check("R3 start pulse", cmd_start, m_start);
    check("R4 reset pulse", cmd_reset, m_rst);
    check("R12 irq", irq, m_irq);
  endtask

  // drive at falling edge, return at the next falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d, input bit err_p = 0, input bit done_p = 0);
    bit aligned;
    int idx;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; seq_err = err_p; seq_done = done_p;
    @(negedge clk);
    reg_wr = 1'b0; seq_err = 1'b0; seq_done = 1'b0;
    aligned = (a[1:0] == 2'b00);
    idx = int'(a[4:2]);
    m_start = 1'b0; m_rst = 1'b0;
    if (done_p && m_cfg[30]) m_irq = 1'b1;
    else if (aligned && idx == 0) m_irq = 1'b0;
    if (aligned && idx == 0) begin
      m_cfg = d & CFG_MASK;
      m_err = err_p ? 1'b1 : d[29];
      m_start = d[31]; m_rst = ~d[31];
      if (!d[31]) begin m_kptr = 0; m_iptr = 0; end
    end else if (err_p) m_err = 1'b1;
    if (aligned && idx == 1) m_src = d & 32'hFFFF_FFF0;
    if (aligned && idx == 2) m_dst = d & 32'hFFFF_FFF0;
    if (aligned && idx == 3) begin m_key[127-32*m_kptr -: 32] = d; m_kptr = (m_kptr + 1) % 4; end
    if (aligned && idx == 4) begin m_iv[127-32*m_iptr -: 32] = d; m_iptr = (m_iptr + 1) % 4; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    m_start = 1'b0; m_rst = 1'b0;
  endtask

  task automatic seq_pulse(input bit e, input bit dn, input bit wb, input logic [31:0] s, input logic [31:0] t);
    @(negedge clk);
    seq_err = e; seq_done = dn; seq_wb = wb; seq_src = s; seq_dst = t;
    @(negedge clk);
    seq_err = 1'b0; seq_done = 1'b0; seq_wb = 1'b0;
    m_start = 1'b0; m_rst = 1'b0;
    if (e) m_err = 1'b1;
    if (dn && m_cfg[30]) m_irq = 1'b1;
    if (wb) begin m_src = s & 32'hFFFF_FFF0; m_dst = t & 32'hFFFF_FFF0; end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    #20; rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_all();
    check("R1 addr outputs", {src_addr, dst_addr}, 0);

    // R7 key order and wrap
    wr(5'h0C, 32'h1111_0000); wr(5'h0C, 32'h2222_0000);
    wr(5'h0C, 32'h3333_0000); wr(5'h0C, 32'h4444_0000);
    check("R7 key assembled", key, 128'h1111_0000_2222_0000_3333_0000_4444_0000);
    wr(5'h0C, 32'hAAAA_5555);
    check("R7 key wrap", key[127:96], 32'hAAAA_5555);
    // R8 iv order
    wr(5'h10, 32'hA0); wr(5'h10, 32'hB0); wr(5'h10, 32'hC0); wr(5'h10, 32'hD0);
    check("R8 iv assembled", iv, {32'hA0, 32'hB0, 32'hC0, 32'hD0});
    check_all();

    // R4 pointer clear: key ptr at 1, iv ptr at 0
    wr(5'h0C, 32'hBEEF_0001);
    wr(5'h00, 32'h0000_0000);
    check("R4 reset pulse", cmd_reset, 1'b1);
    check("R4 no start", cmd_start, 1'b0);
    idle(1);
    check("R4 reset pulse ends", cmd_reset, 1'b0);
    wr(5'h0C, 32'hCAFE_0002);
    check("R4 key ptr cleared", key[127:96], 32'hCAFE_0002);
    check_all();

    // R3 / R5 start pulse and busy
    wr(5'h00, 32'h9800_1005);
    check("R3 start pulse", cmd_start, 1'b1);
    read(5'h00, d); check("R5 busy while start pending", d[31], 1'b1);
    check("R2 blocks", cmd_blocks, 12'h005);
    idle(1);
    check("R3 start ends", cmd_start, 1'b0);
    read(5'h00, d); check("R5 idle", d[31], 1'b0);
    seq_busy = 1'b1;
    read(5'h00, d); check("R5 busy from sequencer", d[31], 1'b1);
    seq_busy = 1'b0;
    check_all();

    // R6 error flag
    seq_pulse(1, 0, 0, 0, 0);
    read(5'h00, d); check("R6 err set", d[29], 1'b1);
    idle(3);
    read(5'h00, d); check("R6 err sticky", d[29], 1'b1);
    wr(5'h00, 32'h8000_0000);
    read(5'h00, d); check("R6 err cleared", d[29], 1'b0);
    wr(5'h00, 32'h8000_0000, 1, 0);
    read(5'h00, d); check("R6 pulse beats write", d[29], 1'b1);
    wr(5'h00, 32'h0000_0000);

    // R11 address write-back
    wr(5'h04, 32'h1234_567F); wr(5'h08, 32'h0000_100C);
    check("R10 src aligned", src_addr, 32'h1234_5670);
    check("R10 dst aligned", dst_addr, 32'h0000_1000);
    seq_pulse(0, 0, 1, 32'h0000_2019, 32'h0000_3023);
    check("R11 src writeback", src_addr, 32'h0000_2010);
    check("R11 dst writeback", dst_addr, 32'h0000_3020);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'h04; reg_wdata = 32'h0000_7770;
    seq_wb = 1'b1; seq_src = 32'h0000_8880; seq_dst = 32'h0000_9990;
    @(negedge clk);
    reg_wr = 1'b0; seq_wb = 1'b0;
    m_src = 32'h0000_7770; m_dst = 32'h0000_9990;
    check("R11 software wins", src_addr, 32'h0000_7770);
    check("R11 other reg takes writeback", dst_addr, 32'h0000_9990);

    // R12 interrupt
    wr(5'h00, 32'h4000_0000);
    seq_pulse(0, 1, 0, 0, 0);
    check("R12 irq raised", irq, 1'b1);
    idle(5);
    check("R12 irq held", irq, 1'b1);
    wr(5'h10, 32'h0);
    check("R12 irq held over other writes", irq, 1'b1);
    wr(5'h00, 32'h4000_0000);
    check("R12 irq cleared", irq, 1'b0);
    wr(5'h00, 32'h4000_0000, 0, 1);
    check("R12 done beats clear", irq, 1'b1);
    wr(5'h00, 32'h0000_0000);
    seq_pulse(0, 1, 0, 0, 0);
    check("R12 disabled no irq", irq, 1'b0);

    // R13 unmapped and misaligned writes
    wr(5'h14, 32'hFFFF_FFFF); wr(5'h1C, 32'hFFFF_FFFF); wr(5'h02, 32'hFFFF_FFFF);
    wr(5'h0D, 32'hFFFF_FFFF);
    check_all();

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [4:0] a;
      case ($urandom % 8)
        0: a = 5'h00; 1: a = 5'h04; 2: a = 5'h08; 3, 4: a = 5'h0C;
        5: a = 5'h10; 6: a = 5'h14; default: a = 5'($urandom);
      endcase
      seq_busy = ($urandom % 4) == 0;
      wr(a, $urandom);
      check_all();
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule